// File: doc/BRIEF.md
# Host Interrupt Status Controller

This block gathers single-cycle event pulses from up to eighteen device sources into one latched status register and drives a single interrupt line toward the host. A mask register decides which pending status bits may reach the line; a set bit in the mask blocks its source. Status bits latch whatever the mask holds, so clearing a mask bit for an already pending source raises the line straight away.

The host reaches the block over a small register bus with a word address, separate write and read enables and a 32-bit data path. The mask can be written whole or changed bit-wise through write-one-to-set and write-one-to-clear ports. Status is visible through two read views of the same register: one leaves it untouched, the other empties it after returning it. A write-one-to-clear acknowledge port retires chosen status bits. A configuration input picks whether the line is active-high or active-low.

Top module: `host_irq_ctrl`

## Requirements
- R1: Source input i latches status bit i for i in 0..10, 14, 16 and 17 (0/1 receive buffers at 0 and 3, transmit data 1, transmit transfer 2, receive transfer 4, mailbox events 5 and 6, wake 7, traces 8 and 9, command complete 10, init complete 14, sense enable 16, sense disable 17); pulses on inputs 11, 12, 13 and 15 are ignored and those status and mask bits always read zero.
- R2: After reset the mask reads 0x00001, the status reads zero and the read data output is zero.
- R3: A write to address 0x0 loads the mask from write data bits 17:0 (reserved bits forced to zero); a read of address 0x0 returns the mask; the mask changes only through addresses 0x0, 0x1 and 0x2.
- R4: A write to address 0x1 sets each mask bit whose write data bit is 1 and leaves the others unchanged.
- R5: A write to address 0x2 clears each mask bit whose write data bit is 1 and leaves the others unchanged.
- R6: A read of address 0x3 returns the status and leaves it unchanged.
- R7: A read of address 0x4 returns the status and clears every status bit in the same clock edge.
- R8: A write to address 0x5 clears each status bit whose write data bit is 1; bits written 0 keep their value, and both read views see the result.
- R9: A source pulse in the same cycle as an acknowledge or a clear-on-read of its bit leaves that status bit set.
- R10: The line is asserted while any status bit is 1 with its mask bit 0, with no register between status, mask and line.
- R11: With the polarity input at 1 the asserted line level is 0 and the idle level is 1; with polarity 0 the levels are reversed.
- R12: Read data appears on the output the cycle after the read enable, holds until the next read, and a read of any other address (including the write-only ones 0x1, 0x2, 0x5) returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 18 | Source event pulses, one per status bit |
| addr_i | input | 4 | Register word address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_pol_i | input | 1 | Line polarity: 1 selects active-low |
| irq_o | output | 1 | Host interrupt line |

## Verification
The bench builds the block with its default parameters: eighteen sources, the fixed reserved-bit pattern and a reset mask of 0x00001. With those values every reserved position, the reset mask bit and collisions between source pulses and both clearing paths on a single bit fall inside short directed sequences, and a random phase of mixed bus traffic and sparse pulses then compares line and read data against a behavioural model on every clock under both polarities.

// File: rtl/host_irq_pkg.sv
package host_irq_pkg;

  localparam int OFS_MASK     = 0;
  localparam int OFS_MASK_SET = 1;
  localparam int OFS_MASK_CLR = 2;
  localparam int OFS_STS_ND   = 3;
  localparam int OFS_STS_COR  = 4;
  localparam int OFS_ACK      = 5;

  typedef struct packed {
    logic mask_wr;
    logic mask_set;
    logic mask_clr;
    logic ack_wr;
    logic rd_mask;
    logic rd_nd;
    logic rd_cor;
    logic rd_any;
  } hirq_strb_t;

endpackage

// File: rtl/hirq_decode.sv
module hirq_decode
  import host_irq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output hirq_strb_t        strb_o
);

  always_comb begin
    strb_o          = '0;
    strb_o.mask_wr  = wr_en_i && (addr_i == ADDR_W'(OFS_MASK));
    strb_o.mask_set = wr_en_i && (addr_i == ADDR_W'(OFS_MASK_SET));
    strb_o.mask_clr = wr_en_i && (addr_i == ADDR_W'(OFS_MASK_CLR));
    strb_o.ack_wr   = wr_en_i && (addr_i == ADDR_W'(OFS_ACK));
    strb_o.rd_mask  = rd_en_i && (addr_i == ADDR_W'(OFS_MASK));
    strb_o.rd_nd    = rd_en_i && (addr_i == ADDR_W'(OFS_STS_ND));
    strb_o.rd_cor   = rd_en_i && (addr_i == ADDR_W'(OFS_STS_COR));
    strb_o.rd_any   = rd_en_i;
  end

endmodule

// File: rtl/hirq_mask.sv
module hirq_mask
  import host_irq_pkg::*;
#(
  parameter int                NUM_SRC    = 18,
  parameter logic [NUM_SRC-1:0] VALID_MASK = 18'h347FF,
  parameter logic [NUM_SRC-1:0] MASK_RST   = 18'h00001
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  hirq_strb_t         strb_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] mask_o
);

  logic [NUM_SRC-1:0] mask_d;
  logic [NUM_SRC-1:0] wd_v;

  assign wd_v = wdata_i & VALID_MASK;

  always_comb begin
    mask_d = mask_o;
    if (strb_i.mask_wr)  mask_d = wd_v;
    if (strb_i.mask_set) mask_d = mask_d | wd_v;
    if (strb_i.mask_clr) mask_d = mask_d & ~wd_v;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    if (VALID_MASK[i]) begin : g_flop
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mask_o[i] <= MASK_RST[i];
        else         mask_o[i] <= mask_d[i];
      end
    end else begin : g_tie
      assign mask_o[i] = 1'b0;
    end
  end

  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_i.mask_set |=> ((mask_o & $past(wd_v)) == $past(wd_v))); // R4
  AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_i.mask_clr |=> ((mask_o & $past(wd_v)) == '0)); // R5
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(strb_i.mask_wr || strb_i.mask_set || strb_i.mask_clr) |=> $stable(mask_o)); // R3

endmodule

// File: rtl/hirq_status.sv
module hirq_status
  import host_irq_pkg::*;
#(
  parameter int                 NUM_SRC    = 18,
  parameter logic [NUM_SRC-1:0] VALID_MASK = 18'h347FF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  hirq_strb_t         strb_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] sts_o
);

  logic [NUM_SRC-1:0] src_v;
  logic [NUM_SRC-1:0] clr;
  logic [NUM_SRC-1:0] sts_d;

  assign src_v = src_i & VALID_MASK;

  always_comb begin
    clr = '0;
    if (strb_i.ack_wr) clr = clr | wdata_i;
    if (strb_i.rd_cor) clr = '1;
    // set beats clear
    sts_d = (sts_o & ~clr) | src_v;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    if (VALID_MASK[i]) begin : g_flop
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sts_o[i] <= 1'b0;
        else         sts_o[i] <= sts_d[i];
      end
    end else begin : g_tie
      assign sts_o[i] = 1'b0;
    end
  end

  AST_SRC_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_v) |=> ((sts_o & $past(src_v)) == $past(src_v))); // R9
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_i.ack_wr |=> ((sts_o & $past(wdata_i & ~src_v)) == '0)); // R8
  AST_COR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_i.rd_cor |=> (sts_o == $past(src_v))); // R7

endmodule

// File: rtl/host_irq_ctrl.sv
module host_irq_ctrl
  import host_irq_pkg::*;
#(
  parameter int                 NUM_SRC    = 18,
  parameter int                 ADDR_W     = 4,
  parameter int                 DATA_W     = 32,
  parameter logic [NUM_SRC-1:0] VALID_MASK = 18'h347FF,
  parameter logic [NUM_SRC-1:0] MASK_RST   = 18'h00001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              irq_pol_i,
  output logic              irq_o
);

  localparam int PAD_W = DATA_W - NUM_SRC;

  hirq_strb_t         strb;
  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] sts;
  logic [NUM_SRC-1:0] wd;
  logic               unused_wdata_hi;
  logic               pend;

  assign wd              = wdata_i[NUM_SRC-1:0];
  assign unused_wdata_hi = ^wdata_i[DATA_W-1:NUM_SRC];

  hirq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i  (addr_i),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .strb_o  (strb)
  );

  hirq_mask #(
    .NUM_SRC(NUM_SRC), .VALID_MASK(VALID_MASK), .MASK_RST(MASK_RST)
  ) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strb_i  (strb),
    .wdata_i (wd),
    .mask_o  (mask)
  );

  hirq_status #(
    .NUM_SRC(NUM_SRC), .VALID_MASK(VALID_MASK)
  ) u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (src_i),
    .strb_i  (strb),
    .wdata_i (wd),
    .sts_o   (sts)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (strb.rd_any) begin
      if (strb.rd_nd || strb.rd_cor) rdata_o <= {{PAD_W{1'b0}}, sts};
      else if (strb.rd_mask)         rdata_o <= {{PAD_W{1'b0}}, mask};
      else                           rdata_o <= '0;
    end
  end

  assign pend  = |(sts & ~mask);
  assign irq_o = pend ^ irq_pol_i;

  AST_ND_NO_SIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb.rd_nd && !strb.ack_wr && !(|src_i)) |=> $stable(sts)); // R6
  AST_COR_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb.rd_cor |=> (rdata_o[NUM_SRC-1:0] == $past(sts))); // R7
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o)); // R12
  AST_RSVD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> ((rdata_o[NUM_SRC-1:0] & ~VALID_MASK) == '0)); // R1

endmodule

// File: tb/host_irq_ctrl_tb.sv
module host_irq_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [17:0] VALID = 18'h347FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [17:0] src = '0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pol = 1'b0;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  string req = "R2";

  // reference model state
  logic [17:0] m_mask;
  logic [17:0] m_sts;
  logic [31:0] m_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata),
    .irq_pol_i(pol), .irq_o(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = 18'h00001;
      m_sts  = '0;
      m_rd   = '0;
    end else begin
      logic [17:0] clr;
      logic [17:0] wv;
      wv = wdata[17:0] & VALID;
      clr = '0;
      if (rd_en) begin
        if (addr == 4'd0) m_rd = {14'd0, m_mask};
        else if (addr == 4'd3 || addr == 4'd4) m_rd = {14'd0, m_sts};
        else m_rd = '0;
        if (addr == 4'd4) clr = '1;
      end
      if (wr_en) begin
        if (addr == 4'd0) m_mask = wv;
        if (addr == 4'd1) m_mask = m_mask | wv;
        if (addr == 4'd2) m_mask = m_mask & ~wv;
        if (addr == 4'd5) clr = clr | wdata[17:0];
      end
      m_sts = (m_sts & ~clr) | (src & VALID);
    end
  end

  always @(negedge clk) begin
    logic exp_irq;
    if (!done) begin
      exp_irq = ((m_sts & ~m_mask) != '0) ^ pol;
      n_cmp++;
      if (rdata !== m_rd) begin
        n_bad++;
        $display("FAIL %s rdata actual=%h expected=%h t=%0t", req, rdata, m_rd, $time);
      end
      n_cmp++;
      if (irq !== exp_irq) begin
        n_bad++;
        $display("FAIL %s irq actual=%b expected=%b t=%0t", req, irq, exp_irq, $time);
      end
    end
  end

  task automatic cyc(input logic we, input logic re, input logic [3:0] a,
                     input logic [31:0] d, input logic [17:0] s);
    wr_en = we; rd_en = re; addr = a; wdata = d; src = s;
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0; addr = '0; wdata = '0; src = '0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic finish_run;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #1 rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    // R2: reset values
    req = "R2"; cyc(0, 1, 4'd0, 0, 0); cyc(0, 1, 4'd3, 0, 0); idle(1);
    // R1: each source alone, unmasked, then read and ack
    req = "R1"; cyc(1, 0, 4'd0, 32'h0, 0);
    for (int i = 0; i < 18; i++) begin
      cyc(0, 0, 4'd0, 0, 18'(1) << i);
      cyc(0, 1, 4'd3, 0, 0);
      cyc(1, 0, 4'd5, 32'h3FFFF, 0);
      idle(1);
    end
    // R3: full mask write, reserved bits read zero
    req = "R3"; cyc(1, 0, 4'd0, 32'hFFFF_FFFF, 0); cyc(0, 1, 4'd0, 0, 0);
    cyc(1, 0, 4'd0, 32'h0000_0A5A, 0); cyc(0, 1, 4'd0, 0, 0);
    // R4 / R5: set and clear ports
    req = "R4"; cyc(1, 0, 4'd1, 32'h0003_0001, 0); cyc(0, 1, 4'd0, 0, 0);
    req = "R5"; cyc(1, 0, 4'd2, 32'h0001_0A00, 0); cyc(0, 1, 4'd0, 0, 0);
    cyc(1, 0, 4'd2, 32'h0, 0); cyc(0, 1, 4'd0, 0, 0);
    // R10: pending but masked, then unmask
    req = "R10"; cyc(1, 0, 4'd0, 32'h3FFFF, 0);
    cyc(0, 0, 4'd0, 0, 18'h00404); idle(2);
    cyc(1, 0, 4'd2, 32'h00400, 0); idle(2);
    // R11: polarity flip both ways
    req = "R11"; pol = 1'b1; idle(2);
    cyc(1, 0, 4'd1, 32'h3FFFF, 0); idle(1); pol = 1'b0; idle(1);
    // R6: non-destructive reads repeat
    req = "R6"; cyc(0, 1, 4'd3, 0, 0); cyc(0, 1, 4'd3, 0, 0);
    // R8: partial acknowledge, zeros no effect
    req = "R8"; cyc(0, 0, 4'd0, 0, 18'h30007);
    cyc(1, 0, 4'd5, 32'h0000_0002, 0); cyc(0, 1, 4'd3, 0, 0);
    cyc(1, 0, 4'd5, 32'h0, 0); cyc(0, 1, 4'd4, 0, 0);
    // R7: clear-on-read then ND shows empty
    req = "R7"; cyc(0, 0, 4'd0, 0, 18'h04120);
    cyc(0, 1, 4'd4, 0, 0); cyc(0, 1, 4'd3, 0, 0);
    // R9: source wins over ack and over clear-on-read
    req = "R9"; cyc(0, 0, 4'd0, 0, 18'h00081);
    cyc(1, 0, 4'd5, 32'h00081, 18'h00001); cyc(0, 1, 4'd3, 0, 0);
    cyc(0, 1, 4'd4, 0, 18'h20000); cyc(0, 1, 4'd3, 0, 0);
    // R12: write-only and unused addresses read zero; hold between reads
    req = "R12"; cyc(0, 1, 4'd1, 0, 0); idle(2); cyc(0, 1, 4'd5, 0, 0);
    cyc(0, 1, 4'd0, 0, 0); idle(2); cyc(0, 1, 4'd9, 0, 0);
    // mixed random traffic
    req = "R1 R3-R12 random";
    for (int n = 0; n < 600; n++) begin
      logic [3:0]  a;
      logic [17:0] s;
      logic        we, re;
      a  = 4'($urandom_range(0, 6));
      we = ($urandom_range(0, 2) == 0);
      re = !we && ($urandom_range(0, 1) == 0);
      s  = ($urandom_range(0, 3) == 0) ? 18'($urandom) & 18'($urandom) : 18'd0;
      if (n % 97 == 0) pol = ~pol;
      cyc(we, re, a, $urandom, s);
    end
    idle(2);
    finish_run();
  end

endmodule